// File: doc/BRIEF.md
# Software Write-Protection Key Sequencer

This block sits in front of the page write engine of a byte-wide non-volatile memory core. It sees every write cycle that reaches the core: a one-cycle valid pulse with a 15-bit address and an 8-bit data byte. It keeps one flag, the software write-protection state. For each write it decides in the same cycle whether that write may reach the array. Key writes are matched against fixed address/data pairs. These pairs form a three-write arming prefix and a six-write disarm sequence. Key writes themselves are always withheld.

The matcher is a state machine with seven states:
- `ST_IDLE`: no partial sequence.
- `ST_K1`: `0xAA` has been written at `0x5555`.
- `ST_K2`: `0x55` has followed at `0x2AAA`.
- `ST_ARMED`: `0xA0` at `0x5555` has completed the prefix.
- `ST_D3`: `0x80` at `0x5555` has been seen after `ST_K2`.
- `ST_D4`: `0xAA` at `0x5555` has followed.
- `ST_D5`: `0x55` at `0x2AAA` has followed.

Transitions:
- **start**: `ST_IDLE` to `ST_K1`.
- **step2**: `ST_K1` to `ST_K2`.
- **arm**: `ST_K2` to `ST_ARMED`.
- **commit**: any write in `ST_ARMED`. It is permitted, sets protection and returns to `ST_IDLE`.
- **dis3**: `ST_K2` to `ST_D3`.
- **dis4**: `ST_D3` to `ST_D4`.
- **dis5**: `ST_D4` to `ST_D5`.
- **unlock**: `0x20` at `0x5555` in `ST_D5`. It clears protection and returns to `ST_IDLE`.
- **fallback**: any other write in a partial state. It returns to `ST_IDLE`, or to `ST_K1` when the write is itself `0xAA` at `0x5555`.
- **restore**: a synchronous `restore_default` from any state.

Top module: `wp_key_sequencer`

## Requirements
- R1: After reset, `wp_protected` is 0 and the matcher is idle, so an ordinary write is permitted.
- R2: While unprotected, a write that is not a key step is permitted in the same cycle as `wr_valid`.
- R3: While protected, a write that is not a key step and does not directly follow the arming prefix is not permitted.
- R4: The write right after the prefix (`0xAA`@`0x5555`, `0x55`@`0x2AAA`, `0xA0`@`0x5555`) is permitted in its own cycle, and `wp_protected` is 1 from the next cycle.
- R5: Each write that advances the matcher (including the prefix writes) is never permitted.
- R6: The prefix followed by idle cycles and no data write leaves `wp_protected` unchanged.
- R7: Six writes (`0xAA`@`0x5555`, `0x55`@`0x2AAA`, `0x80`@`0x5555`, `0xAA`@`0x5555`, `0x55`@`0x2AAA`, `0x20`@`0x5555`) clear `wp_protected` after the sixth. None of the six is permitted, and a sequence broken before the sixth leaves protection set.
- R8: A write that breaks a partial sequence returns the matcher to idle and is judged as a first step. If it is `0xAA`@`0x5555`, it starts a new sequence. Otherwise it is treated as an ordinary write.
- R9: `wr_permit` is never 1 while `wr_valid` is 0.
- R10: `restore_default` clears protection and the matcher on the next edge. Any write in that same cycle is not permitted.
- R11: `wp_protected` changes only after a write cycle or a restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restore_default | input | 1 | Synchronous return to the unprotected idle default |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data byte |
| wp_protected | output | 1 | Software protection state |
| wr_permit | output | 1 | Write may reach the array (same cycle as `wr_valid`) |

## Verification
A wrong matcher state shows up at `wr_permit` on the very next write. A write is then withheld that should pass, or one passes that should be withheld. A wrong protection flag shows the same way, and it also shows on `wp_protected` one cycle after the write that set it. The bench sweeps all 256 data bytes as the third write after a partial prefix. It checks each byte's permit against an arithmetic expectation, and it drives full, broken, restarted and idle-stalled sequences in both protection modes.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_K1    = 3'd1,
        ST_K2    = 3'd2,
        ST_ARMED = 3'd3,
        ST_D3    = 3'd4,
        ST_D4    = 3'd5,
        ST_D5    = 3'd6
    } wp_state_e;

    typedef struct packed {
        logic aa_hi;   // AA at the high key address
        logic x55_lo;  // 55 at the low key address
        logic a0_hi;   // A0 at the high key address
        logic x80_hi;  // 80 at the high key address
        logic x20_hi;  // 20 at the high key address
    } wp_key_t;
endpackage

// File: rtl/wp_key_decode.sv
module wp_key_decode #(
    parameter int          ADDR_W  = 15,
    parameter int          DATA_W  = 8,
    parameter logic [14:0] KEY_HI  = 15'h5555,
    parameter logic [14:0] KEY_LO  = 15'h2AAA,
    parameter logic [7:0]  C_OPEN  = 8'hAA,
    parameter logic [7:0]  C_SEC   = 8'h55,
    parameter logic [7:0]  C_ARM   = 8'hA0,
    parameter logic [7:0]  C_DIS   = 8'h80,
    parameter logic [7:0]  C_FIN   = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output wp_pkg::wp_key_t   key
);
    logic at_hi, at_lo;

    always_comb begin
        at_hi        = (addr == ADDR_W'(KEY_HI));
        at_lo        = (addr == ADDR_W'(KEY_LO));
        key.aa_hi    = at_hi && (data == DATA_W'(C_OPEN));
        key.x55_lo   = at_lo && (data == DATA_W'(C_SEC));
        key.a0_hi    = at_hi && (data == DATA_W'(C_ARM));
        key.x80_hi   = at_hi && (data == DATA_W'(C_DIS));
        key.x20_hi   = at_hi && (data == DATA_W'(C_FIN));
    end
endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
    import wp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restore,
    input  logic      wr_valid,
    input  wp_key_t   key,
    output wp_state_e state,
    output logic      arm_fire,
    output logic      unlock_fire,
    output logic      key_hold,
    output logic      ordinary
);
    wp_state_e state_q, state_d;
    logic      take;

    assign take  = wr_valid && !restore;
    assign state = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= ST_IDLE;
        else if (restore) state_q <= ST_IDLE;
        else              state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (take) begin
            unique case (state_q)
                ST_IDLE:  state_d = key.aa_hi ? ST_K1 : ST_IDLE;
                ST_K1:    state_d = key.x55_lo ? ST_K2
                                  : (key.aa_hi ? ST_K1 : ST_IDLE);
                ST_K2:    state_d = key.a0_hi  ? ST_ARMED
                                  : key.x80_hi ? ST_D3
                                  : (key.aa_hi ? ST_K1 : ST_IDLE);
                ST_ARMED: state_d = ST_IDLE;
                ST_D3:    state_d = key.aa_hi ? ST_D4 : ST_IDLE;
                ST_D4:    state_d = key.x55_lo ? ST_D5
                                  : (key.aa_hi ? ST_K1 : ST_IDLE);
                ST_D5:    state_d = key.x20_hi ? ST_IDLE
                                  : (key.aa_hi ? ST_K1 : ST_IDLE);
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // per-write decisions
    always_comb begin
        arm_fire    = 1'b0;
        unlock_fire = 1'b0;
        key_hold    = 1'b0;
        if (take) begin
            unique case (state_q)
                ST_IDLE:  key_hold = key.aa_hi;
                ST_K1:    key_hold = key.x55_lo || key.aa_hi;
                ST_K2:    key_hold = key.a0_hi || key.x80_hi || key.aa_hi;
                ST_ARMED: arm_fire = 1'b1;
                ST_D3:    key_hold = key.aa_hi;
                ST_D4:    key_hold = key.x55_lo || key.aa_hi;
                ST_D5: begin
                    unlock_fire = key.x20_hi;
                    key_hold    = key.x20_hi || key.aa_hi;
                end
                default:  key_hold = 1'b0;
            endcase
        end
        ordinary = take && !key_hold && !arm_fire;
    end

    // R8: a broken sequence ends in idle or a fresh first step
    p_break_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ordinary && state_q != ST_IDLE) |=> (state_q == ST_IDLE));

    // R5: a matched step always lands in a non-idle state
    p_step_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && key_hold && !unlock_fire) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/wp_gate.sv
module wp_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic restore,
    input  logic wr_valid,
    input  logic arm_fire,
    input  logic unlock_fire,
    input  logic key_hold,
    input  logic ordinary,
    output logic prot,
    output logic permit
);
    logic prot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           prot_q <= 1'b0;
        else if (restore)     prot_q <= 1'b0;
        else if (arm_fire)    prot_q <= 1'b1;
        else if (unlock_fire) prot_q <= 1'b0;
    end

    always_comb begin
        prot   = prot_q;
        permit = arm_fire || (ordinary && !prot_q);
    end

    p_permit_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> wr_valid);
    p_key_withheld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_hold |-> !permit);
    p_arm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arm_fire |=> prot);
    p_unlock_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_fire && !restore) |=> !prot);
    p_restore_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> !prot);
    p_restore_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restore |-> !permit);
    p_prot_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !restore) |=> $stable(prot));
endmodule

// File: rtl/wp_key_sequencer.sv
module wp_key_sequencer #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore_default,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wp_protected,
    output logic              wr_permit
);
    import wp_pkg::*;

    wp_key_t   key;
    wp_state_e state;
    logic      arm_fire, unlock_fire, key_hold, ordinary;

    wp_key_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .key  (key)
    );

    wp_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore     (restore_default),
        .wr_valid    (wr_valid),
        .key         (key),
        .state       (state),
        .arm_fire    (arm_fire),
        .unlock_fire (unlock_fire),
        .key_hold    (key_hold),
        .ordinary    (ordinary)
    );

    wp_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore     (restore_default),
        .wr_valid    (wr_valid),
        .arm_fire    (arm_fire),
        .unlock_fire (unlock_fire),
        .key_hold    (key_hold),
        .ordinary    (ordinary),
        .prot        (wp_protected),
        .permit      (wr_permit)
    );

    // R3: protected, idle matcher, non-key write is blocked
    p_protected_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_protected && wr_valid && state == ST_IDLE && !key.aa_hi) |-> !wr_permit);
    // R1: reset leaves the matcher idle
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state == ST_IDLE));
endmodule

// File: tb/test_wp_key_sequencer.sv
`timescale 1ns/1ps
module test_wp_key_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restore_default = 1'b0;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wp_protected, wr_permit;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    wp_key_sequencer i_wp_key_sequencer (
        .clk(clk), .rst_n(rst_n), .restore_default(restore_default),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wp_protected(wp_protected), .wr_permit(wr_permit)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d,
                      input logic exp, input string tag);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1 check(wr_permit, exp, tag);
        @(posedge clk);
        #0.5 wr_valid = 1'b0;
    endtask

    task automatic chk_prot(input logic exp, input string tag);
        @(negedge clk);
        #1 check(wp_protected, exp, tag);
        check(wr_permit, 1'b0, "R9 idle permit");
    endtask

    task automatic restore();
        @(negedge clk); restore_default = 1'b1;
        @(posedge clk); #0.5 restore_default = 1'b0;
    endtask

    task automatic prefix(input string tag);
        wr(15'h5555, 8'hAA, 1'b0, tag);
        wr(15'h2AAA, 8'h55, 1'b0, tag);
        wr(15'h5555, 8'hA0, 1'b0, tag);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        // R1 / R2
        chk_prot(1'b0, "R1 reset state");
        wr(15'h0100, 8'h11, 1'b1, "R1 R2 ordinary write after reset");
        wr(15'h5554, 8'hAA, 1'b1, "R2 near-key address");
        // R5 / R4: arm from unprotected
        prefix("R5 prefix withheld");
        wr(15'h0100, 8'h12, 1'b1, "R4 data after prefix");
        chk_prot(1'b1, "R4 protection on");
        // R3
        wr(15'h0200, 8'h34, 1'b0, "R3 protected ordinary write");
        wr(15'h5555, 8'hA0, 1'b0, "R3 lone A0 write");
        chk_prot(1'b1, "R3 still protected");
        // R4 in protected mode, only one write per prefix
        prefix("R5 prefix in protected mode");
        wr(15'h0300, 8'h56, 1'b1, "R4 prefixed write when protected");
        wr(15'h0301, 8'h57, 1'b0, "R3 second write not covered");
        // R7 broken disarm keeps protection
        wr(15'h5555, 8'hAA, 1'b0, "R7 d1");
        wr(15'h2AAA, 8'h55, 1'b0, "R7 d2");
        wr(15'h5555, 8'h80, 1'b0, "R7 d3");
        wr(15'h5555, 8'hAA, 1'b0, "R7 d4");
        wr(15'h2AAA, 8'h55, 1'b0, "R7 d5");
        wr(15'h5555, 8'h21, 1'b0, "R7 R8 wrong sixth step");
        chk_prot(1'b1, "R7 broken disarm keeps protection");
        // R7 full disarm
        wr(15'h5555, 8'hAA, 1'b0, "R7 d1");
        wr(15'h2AAA, 8'h55, 1'b0, "R7 d2");
        wr(15'h5555, 8'h80, 1'b0, "R7 d3");
        wr(15'h5555, 8'hAA, 1'b0, "R7 d4");
        wr(15'h2AAA, 8'h55, 1'b0, "R7 d5");
        wr(15'h5555, 8'h20, 1'b0, "R7 d6");
        chk_prot(1'b0, "R7 protection off");
        wr(15'h0400, 8'h99, 1'b1, "R7 R2 write after disarm");
        // R6 prefix alone
        prefix("R6 prefix");
        repeat (10) @(negedge clk);
        chk_prot(1'b0, "R6 prefix alone no change");
        wr(15'h0500, 8'h01, 1'b1, "R6 R4 late data write");
        chk_prot(1'b1, "R6 R4 protection on after data");
        // R8 break in protected mode
        wr(15'h5555, 8'hAA, 1'b0, "R8 step1");
        wr(15'h2AAA, 8'h55, 1'b0, "R8 step2");
        wr(15'h0600, 8'h77, 1'b0, "R8 breaking write protected");
        wr(15'h5555, 8'hA0, 1'b0, "R8 orphan A0 ordinary");
        wr(15'h0601, 8'h78, 1'b0, "R8 no unlock after break");
        // R10 restore with a write in the same cycle
        @(negedge clk);
        restore_default = 1'b1; wr_valid = 1'b1; wr_addr = 15'h0700; wr_data = 8'h01;
        #1 check(wr_permit, 1'b0, "R10 write during restore");
        @(posedge clk); #0.5 begin restore_default = 1'b0; wr_valid = 1'b0; end
        chk_prot(1'b0, "R10 R11 restore clears");
        // R8 restart on AA@5555 while unprotected
        wr(15'h5555, 8'hAA, 1'b0, "R8 first");
        wr(15'h5555, 8'hAA, 1'b0, "R8 restart first");
        wr(15'h2AAA, 8'h55, 1'b0, "R8 second");
        wr(15'h5555, 8'hA0, 1'b0, "R8 third");
        wr(15'h0800, 8'h42, 1'b1, "R8 R4 data after restarted prefix");
        chk_prot(1'b1, "R8 protected after restart");
        restore();
        // sweep: third write at the high key address, every data byte (R5 R8 R2)
        for (int d = 0; d < 256; d++) begin
            logic exp;
            exp = !(d == 8'hA0 || d == 8'h80 || d == 8'hAA);
            wr(15'h5555, 8'hAA, 1'b0, "R5 sweep s1");
            wr(15'h2AAA, 8'h55, 1'b0, "R5 sweep s2");
            wr(15'h5555, 8'(d), exp, "R8 sweep third byte");
            restore();
        end
        // sweep in protected mode: ordinary addresses stay blocked (R3)
        prefix("R5 re-arm");
        wr(15'h0000, 8'h00, 1'b1, "R4 re-arm data");
        for (int a = 0; a < 64; a++) begin
            wr(15'(a * 509 + 3), 8'(a * 7), 1'b0, "R3 protected sweep");
        end
        chk_prot(1'b1, "R11 protection unchanged by blocked writes");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule